// File: doc/BRIEF.md
# Match-compare event timer

This block is a register-mapped up-counter that raises an interrupt when its count reaches a programmed compare value. It is meant to produce a system tick, either as a one-shot event or, with automatic restart, as a periodic one. Software sees six word registers on a simple bus with address, write enable, write data and read data. Reads are combinational from the address.

The counter does not run on the bus clock. It advances on a slow tick-enable strobe, which first passes through a divider with a programmable ratio. A request to zero the counter is treated as crossing into that slow tick domain. It completes only on the second tick strobe after the write. Until then a pending flag in the status word stays set, and software polls that flag before it re-enables counting.

Register offsets: compare value 0x00, count 0x04 (read-only), control 0x08, clear 0x0C (write strobe), divider select 0x10, status 0x14 (read-only). Unlisted offsets read 0.

Top module: `match_event_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, nothing is pending and the interrupt output is low.
- R2: A write to offset 0x00 sets the compare value, which reads back from the next cycle, whether the counter runs or not.
- R3: Control bit 0 (run) lets the count advance. With run at 0 the count holds its value, and so does the divider phase.
- R4: Divider select bits [1:0] at 0x10 hold a value v, and the count then advances once every v+1 tick strobes. A write to 0x10, or a completed clear, restarts the divider phase.
- R5: Any write to 0x0C sets status bit 10 from the next cycle. The count becomes 0 and bit 10 drops on the second tick strobe strictly after the write cycle. A further write while the flag is pending restarts this wait.
- R6: The count wraps from its all-ones value to 0.
- R7: While running, when the count becomes equal to the compare value, irq_o pulses high for exactly one bus cycle, one cycle later. It does not pulse again while the equality persists.
- R8: With control bit 1 (restart on match) set, an advance taken while the count equals the compare value loads 0 instead of incrementing.
- R9: With run at 0 no interrupt is produced, even if the count equals the compare value.
- R10: Writes to the count (0x04) and status (0x14) offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick strobe, one bus cycle wide |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Single-cycle event pulse |

## Verification
The bench builds the timer with an 8-bit counter (CNT_W = 8) and keeps the default divider and clear-latency widths. With that width, wrap-around past the all-ones count is reached within a few hundred ticks. It also makes periodic restart with a small compare value and matches seen after a wrap quick to exercise. The tick strobe spacing is varied between every cycle, every other cycle and every fifth cycle. This separates the clear latency, which counts ticks, from the bus cycles in which the pending flag is polled.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

    // Byte offsets of the word registers
    localparam logic [7:0] OFS_MATCH = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h08;
    localparam logic [7:0] OFS_CLEAR = 8'h0C;
    localparam logic [7:0] OFS_PSCL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;

    // Field positions decoded by software
    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_RELOAD_BIT = 1;
    localparam int STAT_PEND_BIT   = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_CTRL,
        SEL_CLEAR,
        SEL_PSCL,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [7:0] a);
        reg_sel_e s;
        case (a)
            OFS_MATCH: s = SEL_MATCH;
            OFS_COUNT: s = SEL_COUNT;
            OFS_CTRL:  s = SEL_CTRL;
            OFS_CLEAR: s = SEL_CLEAR;
            OFS_PSCL:  s = SEL_PSCL;
            OFS_STAT:  s = SEL_STAT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mtm_prescale.sv
module mtm_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] div_sel,
    output logic            adv_o
);

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        adv_o = run && tick_en && (st_q.phase == div_sel);
        if (restart) begin
            st_d.phase = '0;
        end else if (run && tick_en) begin
            st_d.phase = adv_o ? '0 : st_q.phase + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The phase returns to zero after every advance
    assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> (st_q.phase == '0));

    // Without run or a tick the phase is frozen unless restarted
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(st_q.phase));

endmodule

// File: rtl/mtm_clear_sync.sv
module mtm_clear_sync #(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr_req,
    output logic pending_o,
    output logic fire_o
);

    localparam int STG_W = $clog2(SYNC_TICKS + 1);
    localparam logic [STG_W-1:0] LAST_STG = STG_W'(SYNC_TICKS - 1);

    typedef struct packed {
        logic             pending;
        logic [STG_W-1:0] stage;
    } clr_state_t;

    clr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = st_q.pending && tick_en && (st_q.stage == LAST_STG);
        if (clr_req) begin
            st_d.pending = 1'b1;
            st_d.stage   = '0;
        end else if (st_q.pending && tick_en) begin
            if (fire_o) begin
                st_d.pending = 1'b0;
                st_d.stage   = '0;
            end else begin
                st_d.stage = st_q.stage + STG_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pending;

    // Pending only ever rises because of a write to the clear register
    assert_pend_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(clr_req));

    // A completed clear drops the flag unless a new request arrives together
    assert_pend_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !clr_req) |=> !pending_o);

endmodule

// File: rtl/mtm_counter.sv
module mtm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic             adv,
    input  logic             clr_fire,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit_o = en && (st_q.count == match_val);
        if (clr_fire) begin
            st_d.count = '0;
        end else if (adv) begin
            st_d.count = (reload && hit_o) ? '0 : st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (count_o == '0));

    assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr_fire) |=> (count_o == $past(count_o)));

    // Plain advance is modulo 2**CNT_W, which covers the wrap
    assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr_fire && !(reload && hit_o)) |=> (count_o == $past(count_o) + CNT_W'(1)));

    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && reload && hit_o) |=> (count_o == '0));

endmodule

// File: rtl/match_event_timer.sv
module match_event_timer #(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 5,
    parameter int PS_W       = 2,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    import mtm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] match;
        logic             run;
        logic             reload;
        logic [PS_W-1:0]  div_sel;
        logic             hit_prev;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;

    reg_sel_e         sel;
    logic             wr_match, wr_ctrl, wr_clear, wr_pscl;
    logic             adv, clr_fire, clr_pending, hit;
    logic [CNT_W-1:0] count;

    assign sel      = decode_sel(8'(bus_addr));
    assign wr_match = bus_we && (sel == SEL_MATCH);
    assign wr_ctrl  = bus_we && (sel == SEL_CTRL);
    assign wr_clear = bus_we && (sel == SEL_CLEAR);
    assign wr_pscl  = bus_we && (sel == SEL_PSCL);

    mtm_prescale #(.PS_W(PS_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (st_q.run),
        .restart (wr_pscl || clr_fire),
        .div_sel (st_q.div_sel),
        .adv_o   (adv)
    );

    mtm_clear_sync #(.SYNC_TICKS(SYNC_TICKS)) u_clear (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .clr_req   (wr_clear),
        .pending_o (clr_pending),
        .fire_o    (clr_fire)
    );

    mtm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_q.run),
        .reload    (st_q.reload),
        .adv       (adv),
        .clr_fire  (clr_fire),
        .match_val (st_q.match),
        .count_o   (count),
        .hit_o     (hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_match) st_d.match = bus_wdata[CNT_W-1:0];
        if (wr_ctrl) begin
            st_d.run    = bus_wdata[CTRL_RUN_BIT];
            st_d.reload = bus_wdata[CTRL_RELOAD_BIT];
        end
        if (wr_pscl) st_d.div_sel = bus_wdata[PS_W-1:0];
        st_d.hit_prev = hit;
        st_d.irq      = hit && !st_q.hit_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_MATCH: bus_rdata = 32'(st_q.match);
            SEL_COUNT: bus_rdata = 32'(count);
            SEL_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]    = st_q.run;
                bus_rdata[CTRL_RELOAD_BIT] = st_q.reload;
            end
            SEL_PSCL:  bus_rdata = 32'(st_q.div_sel);
            SEL_STAT:  bus_rdata[STAT_PEND_BIT] = clr_pending;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(st_q.run));

    assert_match_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> (st_q.match == $past(bus_wdata[CNT_W-1:0])));

    assert_ro_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (sel == SEL_COUNT || sel == SEL_STAT)) |=>
            ($stable(st_q.match) && $stable(st_q.run) && $stable(st_q.reload)));

endmodule

// File: tb/match_event_timer_bench.sv
module match_event_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int ADDR_W     = 5;
    localparam int MOD        = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    tick_gap = 1;
    string cur_req = "R1";

    // behavioural reference state
    int m_match, m_count, m_ps, m_phase, m_stage;
    bit m_run, m_reload, m_pend, m_hitprev, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_event_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_match_event_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_match = 0; m_count = 0; m_ps = 0; m_phase = 0; m_stage = 0;
            m_run = 0; m_reload = 0; m_pend = 0; m_hitprev = 0; m_irq = 0;
        end else begin
            bit hit, fire, adv, wr;
            int a;
            a    = int'(bus_addr);
            wr   = bus_we;
            hit  = m_run && (m_count == m_match);
            fire = m_pend && tick_en && (m_stage == 1);
            adv  = m_run && tick_en && (m_phase == m_ps);
            m_irq     = hit && !m_hitprev;
            m_hitprev = hit;
            if (fire) m_count = 0;
            else if (adv) m_count = (m_reload && hit) ? 0 : (m_count + 1) % MOD;
            if ((wr && a == 'h10) || fire) m_phase = 0;
            else if (m_run && tick_en) m_phase = adv ? 0 : m_phase + 1;
            if (wr && a == 'h0C) begin
                m_pend = 1; m_stage = 0;
            end else if (m_pend && tick_en) begin
                if (m_stage == 1) begin m_pend = 0; m_stage = 0; end
                else m_stage = m_stage + 1;
            end
            if (wr && a == 'h00) m_match = int'(bus_wdata) % MOD;
            if (wr && a == 'h08) begin m_run = bus_wdata[0]; m_reload = bus_wdata[1]; end
            if (wr && a == 'h10) m_ps = int'(bus_wdata[1:0]);
        end
    end

    function automatic logic [31:0] model_rd(input int a);
        case (a)
            'h00: return 32'(m_match);
            'h04: return 32'(m_count);
            'h08: return {30'd0, m_reload, m_run};
            'h10: return 32'(m_ps);
            'h14: return 32'(m_pend) << 10;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic cycle(input bit we, input int a, input int d);
        @(negedge clk);
        if (rst_n) begin
            chk(cur_req, "rdata", bus_rdata, model_rd(int'(bus_addr)));
            chk(cur_req, "irq", 32'(irq_o), 32'(m_irq));
        end
        bus_we    = we;
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        tick_en   = (tick_gap != 0) && (cyc % tick_gap == 0);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, (i % 3 == 0) ? 'h14 : 'h04, 0);
    endtask

    task automatic peek(input string req, input logic [31:0] exp);
        #1;
        chk(req, "peek", bus_rdata, exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        cur_req = "R1";
        tick_gap = 0;
        begin
            int offs[6] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14};
            foreach (offs[k]) begin
                cycle(0, offs[k], 0);
                peek("R1", 32'd0);
            end
        end
        chk("R1", "irq", 32'(irq_o), 32'd0);

        // R2: compare value written while stopped reads back
        cur_req = "R2";
        cycle(1, 'h00, 5);
        cycle(0, 'h00, 0);
        peek("R2", 32'd5);

        // R7, R3: run with divide by 1, single pulse at count 5
        cur_req = "R7";
        tick_gap = 1;
        cycle(1, 'h10, 0);
        cycle(1, 'h08, 1);
        idle(30);

        // R6: run through the all-ones count and back to the compare value
        cur_req = "R6";
        idle(270);

        // R8: periodic restart at compare value 10
        cur_req = "R8";
        cycle(1, 'h00, 10);
        cycle(1, 'h08, 3);
        idle(300);
        idle(60);

        // R4: divide by 4 with a tick every other cycle, then divide by 2
        cur_req = "R4";
        cycle(1, 'h08, 1);
        cycle(1, 'h00, 200);
        tick_gap = 2;
        cycle(1, 'h10, 3);
        idle(100);
        tick_gap = 1;
        cycle(1, 'h10, 1);
        idle(40);
        cycle(1, 'h10, 2);
        idle(30);

        // R3, R9: stopped counter holds and raises nothing at equality
        cur_req = "R9";
        cycle(1, 'h08, 0);
        idle(5);
        cycle(1, 'h00, m_count);
        idle(15);
        cur_req = "R3";
        cycle(1, 'h08, 1);
        idle(10);

        // R5: clear with sparse ticks, pending seen, then restarted wait
        cur_req = "R5";
        tick_gap = 5;
        cycle(1, 'h0C, 0);
        cycle(0, 'h14, 0);
        peek("R5", 32'h0000_0400);
        idle(3);
        cycle(1, 'h0C, 7);
        idle(20);
        cycle(0, 'h14, 0);
        peek("R5", 32'd0);
        tick_gap = 1;
        cycle(1, 'h0C, 0);
        idle(6);

        // R10: writes to read-only offsets leave state alone
        cur_req = "R10";
        cycle(1, 'h04, 'h55);
        cycle(1, 'h14, 'h400);
        idle(8);

        summary();
        $finish;
    end

endmodule